// File: doc/BRIEF.md
# Protected Pad Configuration Register Bank

This block holds the configuration of a set of chip pads for a pin-multiplexing controller. Each pad has one configuration word. The word carries a four-bit function select, a two-bit pull mode and a two-bit drive-strength code. The decoded fields leave the block as flat per-pad vectors that feed the pad cells and the signal crossbar. The bank also holds two three-bit routing selects. Each one picks which of eight sources (high impedance or one of seven internal peripherals) drives a management-data (MDIO) channel.

Software reaches the bank through a simple APB-style slave with zero wait states. Read data is combinational during the access phase, and a write commits on the clock edge that ends the access phase. Every configuration write is guarded by a protection register at byte offset 0x400. The key that software writes there is the protection register's own full bus address. Setting bit 0 of the key opens the bank, and clearing bit 0 closes it again. Any other value written to the protection register is dropped.

The MDIO selects sit at 0x404 (channel 0) and 0x408 (channel 1). They exist only when `MDIO_EN` is set. A bank built without them reads zero at those offsets and drives its routing outputs to zero.

Top module: `pmx_cfg_bank`

## Requirements
- R1: After reset the bank is locked, every pad field is zero and both routing selects are zero.
- R2: A pad word at byte offset 4*n (n < NUM_PADS) holds the function select in bits [3:0], the pull mode in bits [9:8] (0 none, 1 up, 3 down) and the drive code in bits [11:10] (0..3 for 4, 6, 8, 12 mA). Pad n drives these fields on func_o[4n+3:4n], pull_o[2n+1:2n] and drive_o[2n+1:2n].
- R3: While the bank is unlocked, a write to a pad word changes its outputs at the clock edge that completes the access phase, and later reads return the new fields.
- R4: While the bank is locked, writes to pad words and routing selects leave both the stored values and the outputs unchanged.
- R5: Writing BASE_ADDR+0x400 with bit 0 set to offset 0x400 unlocks the bank. Writing the same value with bit 0 clear locks it.
- R6: A write to offset 0x400 whose bits [31:1] differ from those of BASE_ADDR+0x400 leaves the lock state unchanged.
- R7: A read of offset 0x400 returns the lock state in bit 0 (1 = locked) and zero in all other bits.
- R8: Bits [31:12] and [7:4] of a pad word read as zero whatever was written to them.
- R9: Reads of unmapped offsets return zero, and writes to them change no stored value and no output.
- R10: Offsets 0x404 and 0x408 hold the three-bit routing selects of channel 0 and channel 1 in bits [2:0]. These appear on mdio_sel_o[2:0] and mdio_sel_o[5:3], and the upper write bits are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | Slave select |
| penable_i | input | 1 | Access phase |
| pwrite_i | input | 1 | 1 = write, 0 = read |
| paddr_i | input | ADDR_W | Byte offset in the bank |
| pwdata_i | input | 32 | Write data |
| prdata_o | output | 32 | Read data, valid during a read access |
| func_o | output | 4*NUM_PADS | Function select per pad |
| pull_o | output | 2*NUM_PADS | Pull mode per pad |
| drive_o | output | 2*NUM_PADS | Drive-strength code per pad |
| mdio_sel_o | output | 6 | Routing selects, channel 0 in the low bits |

## Verification
The bound checker checks on every cycle the rules that follow directly from a single access:

- a locked write leaves all outputs frozen;
- the routing selects move only after a write to their offsets;
- a wrong key leaves the lock state unchanged, and a correct key sets or clears it;
- protection read-back reflects the lock state;
- unmapped reads return zero and masked pad bits read as zero.

Only the bench scenarios can show:

- the reset values;
- that a written field lands on the correct pad slice and no neighbour is touched;
- the last-pad and first-unmapped boundaries;
- that long random mixes of keys, locks and writes keep every pad consistent with an independent model.

// File: rtl/pmx_pkg.sv
package pmx_pkg;
  localparam int DATA_W   = 32;
  localparam int FUNC_W   = 4;
  localparam int PULL_W   = 2;
  localparam int DRV_W    = 2;
  localparam int MDIO_W   = 3;
  localparam int MDIO_CH  = 2;
  localparam int FUNC_LSB = 0;
  localparam int PULL_LSB = 8;
  localparam int DRV_LSB  = 10;
  localparam logic [31:0] PROT_OFS = 32'h400;

  typedef struct packed {
    logic [DRV_W-1:0]  drive;
    logic [PULL_W-1:0] pull;
    logic [FUNC_W-1:0] func;
  } pad_cfg_t;

  function automatic pad_cfg_t cfg_unpack(logic [DATA_W-1:0] w);
    pad_cfg_t c;
    c.func  = w[FUNC_LSB +: FUNC_W];
    c.pull  = w[PULL_LSB +: PULL_W];
    c.drive = w[DRV_LSB  +: DRV_W];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] cfg_pack(pad_cfg_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[FUNC_LSB +: FUNC_W] = c.func;
    w[PULL_LSB +: PULL_W] = c.pull;
    w[DRV_LSB  +: DRV_W]  = c.drive;
    return w;
  endfunction
endpackage

// File: rtl/pmx_lock.sv
module pmx_lock
  import pmx_pkg::*;
#(
  parameter logic [31:0] KEY = 32'h0000_0400
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              locked_o
);
  logic locked_q;
  logic key_ok;

  assign key_ok = (wdata_i[DATA_W-1:1] == KEY[DATA_W-1:1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              locked_q <= 1'b1;
    else if (we_i && key_ok)  locked_q <= ~wdata_i[0];
  end

  assign locked_o = locked_q;
endmodule

// File: rtl/pmx_pad_cfg.sv
module pmx_pad_cfg
  import pmx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output pad_cfg_t          cfg_o
);
  pad_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= '0;
    else if (we_i) cfg_q <= cfg_unpack(wdata_i);
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/pmx_mdio_sel.sv
module pmx_mdio_sel
  import pmx_pkg::*;
#(
  parameter bit EN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [MDIO_W-1:0] sel_o
);
  if (EN) begin : g_reg
    logic [MDIO_W-1:0] sel_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   sel_q <= '0;
      else if (we_i) sel_q <= wdata_i[MDIO_W-1:0];
    end
    assign sel_o = sel_q;
  end else begin : g_none
    logic unused_w;
    assign unused_w = we_i ^ (|wdata_i) ^ clk_i ^ rst_ni;
    assign sel_o = '0;
  end
endmodule

// File: rtl/pmx_cfg_bank.sv
module pmx_cfg_bank
  import pmx_pkg::*;
#(
  parameter int          NUM_PADS  = 170,
  parameter int          ADDR_W    = 12,
  parameter logic [31:0] BASE_ADDR = 32'h4006_7000,
  parameter bit          MDIO_EN   = 1'b1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   psel_i,
  input  logic                   penable_i,
  input  logic                   pwrite_i,
  input  logic [ADDR_W-1:0]      paddr_i,
  input  logic [DATA_W-1:0]      pwdata_i,
  output logic [DATA_W-1:0]      prdata_o,
  output logic [NUM_PADS*4-1:0]  func_o,
  output logic [NUM_PADS*2-1:0]  pull_o,
  output logic [NUM_PADS*2-1:0]  drive_o,
  output logic [MDIO_CH*MDIO_W-1:0] mdio_sel_o
);
  localparam int WORD_W    = ADDR_W - 2;
  localparam int PAD_IDX_W = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1;
  localparam logic [31:0] KEY = BASE_ADDR + PROT_OFS;
  localparam logic [WORD_W-1:0] PROT_WORD = WORD_W'(PROT_OFS >> 2);
  localparam logic [WORD_W-1:0] PADS_W    = WORD_W'(NUM_PADS);

  logic [WORD_W-1:0]    word_idx;
  logic [PAD_IDX_W-1:0] pad_sel;
  logic                 wr_en, rd_en;
  logic                 pad_hit, prot_hit;
  logic [MDIO_CH-1:0]   mdio_hit;
  logic                 locked_w;
  pad_cfg_t             cfg_w [NUM_PADS];
  logic [MDIO_W-1:0]    mdio_w [MDIO_CH];
  logic                 unused_addr;

  assign word_idx = paddr_i[ADDR_W-1:2];
  assign unused_addr = ^paddr_i[1:0];
  assign pad_sel  = word_idx[PAD_IDX_W-1:0];
  assign wr_en    = psel_i & penable_i & pwrite_i;
  assign rd_en    = psel_i & ~pwrite_i;
  assign pad_hit  = (word_idx < PADS_W);
  assign prot_hit = (word_idx == PROT_WORD);

  pmx_lock #(.KEY(KEY)) u_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (wr_en & prot_hit),
    .wdata_i  (pwdata_i),
    .locked_o (locked_w)
  );

  for (genvar i = 0; i < NUM_PADS; i++) begin : g_pad
    logic pad_we;
    assign pad_we = wr_en & ~locked_w & pad_hit & (pad_sel == PAD_IDX_W'(i));
    pmx_pad_cfg u_pad (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (pad_we),
      .wdata_i (pwdata_i),
      .cfg_o   (cfg_w[i])
    );
    assign func_o[i*FUNC_W +: FUNC_W] = cfg_w[i].func;
    assign pull_o[i*PULL_W +: PULL_W] = cfg_w[i].pull;
    assign drive_o[i*DRV_W +: DRV_W]  = cfg_w[i].drive;
  end

  for (genvar c = 0; c < MDIO_CH; c++) begin : g_mdio
    assign mdio_hit[c] = MDIO_EN && (word_idx == PROT_WORD + WORD_W'(c + 1));
    pmx_mdio_sel #(.EN(MDIO_EN)) u_sel (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (wr_en & ~locked_w & mdio_hit[c]),
      .wdata_i (pwdata_i),
      .sel_o   (mdio_w[c])
    );
    assign mdio_sel_o[c*MDIO_W +: MDIO_W] = mdio_w[c];
  end

  always_comb begin
    prdata_o = '0;
    if (rd_en) begin
      if (pad_hit)       prdata_o = cfg_pack(cfg_w[pad_sel]);
      else if (prot_hit) prdata_o = {{(DATA_W-1){1'b0}}, locked_w};
      else begin
        for (int c = 0; c < MDIO_CH; c++)
          if (mdio_hit[c]) prdata_o = {{(DATA_W-MDIO_W){1'b0}}, mdio_w[c]};
      end
    end
  end
endmodule

// File: rtl/pmx_cfg_bank_chk.sv
module pmx_cfg_bank_chk
  import pmx_pkg::*;
#(
  parameter int          NUM_PADS  = 170,
  parameter int          ADDR_W    = 12,
  parameter logic [31:0] BASE_ADDR = 32'h4006_7000,
  parameter bit          MDIO_EN   = 1'b1
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   psel_i,
  input logic                   penable_i,
  input logic                   pwrite_i,
  input logic [ADDR_W-1:0]      paddr_i,
  input logic [DATA_W-1:0]      pwdata_i,
  input logic [DATA_W-1:0]      prdata_o,
  input logic [NUM_PADS*4-1:0]  func_o,
  input logic [NUM_PADS*2-1:0]  pull_o,
  input logic [NUM_PADS*2-1:0]  drive_o,
  input logic [MDIO_CH*MDIO_W-1:0] mdio_sel_o,
  input logic                   locked
);
  localparam logic [31:0] KEY = BASE_ADDR + PROT_OFS;
  localparam int W = ADDR_W - 2;

  logic [W-1:0] wd;
  logic wr, rd, is_pad, is_prot, is_mdio, mapped;

  assign wd      = paddr_i[ADDR_W-1:2];
  assign wr      = psel_i & penable_i & pwrite_i;
  assign rd      = psel_i & penable_i & ~pwrite_i;
  assign is_pad  = (32'(wd) < NUM_PADS);
  assign is_prot = (32'(wd) == (PROT_OFS >> 2));
  assign is_mdio = MDIO_EN && ((32'(wd) == (PROT_OFS >> 2) + 1) || (32'(wd) == (PROT_OFS >> 2) + 2));
  assign mapped  = is_pad | is_prot | is_mdio;

  assert_locked_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && locked && (is_pad || is_mdio)) |=>
      ($stable(func_o) && $stable(pull_o) && $stable(drive_o) && $stable(mdio_sel_o)));

  assert_unlocked_pad0_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && !locked && wd == '0) |=> (func_o[3:0] == $past(pwdata_i[3:0])));

  assert_key_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && is_prot && pwdata_i[31:1] == KEY[31:1]) |=> (locked == !$past(pwdata_i[0])));

  assert_bad_key_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && is_prot && pwdata_i[31:1] != KEY[31:1]) |=> $stable(locked));

  assert_prot_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && is_prot) |-> (prdata_o == {31'b0, locked}));

  assert_pad_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && is_pad) |-> (prdata_o[31:12] == '0 && prdata_o[7:4] == '0));

  assert_unmapped_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && !mapped) |-> (prdata_o == '0));

  assert_unmapped_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && !mapped) |=> ($stable(func_o) && $stable(pull_o) && $stable(drive_o) &&
                         $stable(mdio_sel_o) && $stable(locked)));

  assert_mdio_only_on_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && is_mdio) |=> $stable(mdio_sel_o));
endmodule

bind pmx_cfg_bank pmx_cfg_bank_chk #(
  .NUM_PADS(NUM_PADS), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .MDIO_EN(MDIO_EN)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .psel_i(psel_i), .penable_i(penable_i),
  .pwrite_i(pwrite_i), .paddr_i(paddr_i), .pwdata_i(pwdata_i), .prdata_o(prdata_o),
  .func_o(func_o), .pull_o(pull_o), .drive_o(drive_o), .mdio_sel_o(mdio_sel_o),
  .locked(locked_w)
);

// File: tb/pmx_cfg_bank_tb.sv
module pmx_cfg_bank_tb;
  localparam int NP = 170;
  localparam logic [31:0] BASE = 32'h4006_7000;
  localparam logic [31:0] KEY  = BASE + 32'h400;

  logic clk = 1'b0, rst_n = 1'b0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic [NP*4-1:0] func_o;
  logic [NP*2-1:0] pull_o, drive_o;
  logic [5:0] mdio_sel_o;

  always #4 clk = ~clk;

  pmx_cfg_bank #(.NUM_PADS(NP), .ADDR_W(12), .BASE_ADDR(BASE), .MDIO_EN(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite),
    .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
    .func_o(func_o), .pull_o(pull_o), .drive_o(drive_o), .mdio_sel_o(mdio_sel_o)
  );

  int n_tests = 0, n_fail = 0;
  logic [3:0] m_func [NP];
  logic [1:0] m_pull [NP];
  logic [1:0] m_drv  [NP];
  logic [2:0] m_mdio [2];
  logic       m_locked;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  task automatic model_wr(input logic [11:0] a, input logic [31:0] d);
    int w = int'(a[11:2]);
    if (w < NP) begin
      if (!m_locked) begin m_func[w] = d[3:0]; m_pull[w] = d[9:8]; m_drv[w] = d[11:10]; end
    end else if (w == 256) begin
      if (d[31:1] == KEY[31:1]) m_locked = ~d[0];
    end else if (w == 257 || w == 258) begin
      if (!m_locked) m_mdio[w-257] = d[2:0];
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    int w = int'(a[11:2]);
    if (w < NP)   return {20'b0, m_drv[w], m_pull[w], 4'b0, m_func[w]};
    if (w == 256) return {31'b0, m_locked};
    if (w == 257 || w == 258) return {29'b0, m_mdio[w-257]};
    return 32'h0;
  endfunction

  task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    model_wr(a, d);
  endtask

  task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1; #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a);
    logic [31:0] d;
    apb_rd(a, d);
    chk(req, d, exp_rd(a));
  endtask

  task automatic chk_outputs(input string req);
    logic [31:0] act = '0, exp = '0;
    bit bad = 0;
    for (int i = 0; i < NP; i++) begin
      if (!bad && ({drive_o[2*i +: 2], pull_o[2*i +: 2], func_o[4*i +: 4]} !==
                   {m_drv[i], m_pull[i], m_func[i]})) begin
        bad = 1;
        act = {i[15:0], 8'b0, drive_o[2*i +: 2], pull_o[2*i +: 2], func_o[4*i +: 4]};
        exp = {i[15:0], 8'b0, m_drv[i], m_pull[i], m_func[i]};
      end
    end
    chk(req, act, exp);
    chk({req, " mdio R10"}, {26'b0, mdio_sel_o}, {26'b0, m_mdio[1], m_mdio[0]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d, x;
    x = $urandom(32'd20240611);
    m_locked = 1'b1;
    for (int i = 0; i < NP; i++) begin m_func[i] = '0; m_pull[i] = '0; m_drv[i] = '0; end
    m_mdio[0] = '0; m_mdio[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_chk("R1 protect after reset", 12'h400);
    rd_chk("R1 pad0 after reset", 12'h000);
    rd_chk("R1 last pad after reset", 12'(4*(NP-1)));
    chk_outputs("R1 outputs after reset");

    // R4 locked write ignored
    apb_wr(12'h014, 32'h0000_0FFF);
    rd_chk("R4 locked pad write", 12'h014);
    apb_wr(12'h404, 32'h6);
    chk_outputs("R4 locked outputs");

    // R6 bad keys
    apb_wr(12'h400, (KEY ^ 32'h0000_0100) | 32'h1);
    rd_chk("R6 wrong key bit8", 12'h400);
    apb_wr(12'h400, (KEY ^ 32'h8000_0000) | 32'h1);
    rd_chk("R6 wrong key bit31", 12'h400);

    // R5 / R7 unlock
    apb_wr(12'h400, KEY | 32'h1);
    rd_chk("R5 R7 unlocked", 12'h400);

    // R8 / R2 field layout and masking
    apb_wr(12'h000, 32'hFFFF_FFFF);
    apb_rd(12'h000, d);
    chk("R8 masked read pad0", d, 32'h0000_0F0F);
    apb_wr(12'(4*(NP-1)), 32'h0000_0D09);
    apb_rd(12'(4*(NP-1)), d);
    chk("R2 last pad word", d, 32'h0000_0D09);
    chk("R2 last pad func", {28'b0, func_o[4*(NP-1) +: 4]}, 32'h9);
    chk("R2 last pad pull", {30'b0, pull_o[2*(NP-1) +: 2]}, 32'h1);
    chk("R2 last pad drive", {30'b0, drive_o[2*(NP-1) +: 2]}, 32'h3);
    apb_wr(12'h008, 32'h0000_0B0F);
    chk_outputs("R3 R2 pad2 write");

    // R9 unmapped
    apb_wr(12'(4*NP), 32'hFFFF_FFFF);
    rd_chk("R9 first unmapped word", 12'(4*NP));
    apb_wr(12'h40C, 32'hFFFF_FFFF);
    rd_chk("R9 unmapped after mdio", 12'h40C);
    rd_chk("R9 high unmapped", 12'hFFC);
    chk_outputs("R9 outputs untouched");

    // R10 routing selects
    apb_wr(12'h404, 32'h0000_0005);
    apb_wr(12'h408, 32'hFFFF_FFFF);
    rd_chk("R10 mdio ch0", 12'h404);
    rd_chk("R10 mdio ch1", 12'h408);
    chk("R10 mdio outputs", {26'b0, mdio_sel_o}, {26'b0, 3'd7, 3'd5});

    // R5 relock, R4 mdio write ignored
    apb_wr(12'h400, KEY);
    rd_chk("R5 relocked", 12'h400);
    apb_wr(12'h404, 32'h2);
    rd_chk("R4 locked mdio write", 12'h404);
    apb_wr(12'h008, 32'h0);
    chk_outputs("R4 locked pad2");

    // random mix
    apb_wr(12'h400, KEY | 32'h1);
    for (int n = 0; n < 600; n++) begin
      logic [11:0] a;
      logic [31:0] v;
      int r = int'($urandom % 10);
      v = $urandom;
      if (r < 5)       a = 12'(4 * ($urandom % NP));
      else if (r == 5) begin a = 12'h400; v = ($urandom % 4 != 0) ? (KEY | ($urandom % 2)) : v; end
      else if (r == 6) a = 12'h404 + 12'(4 * ($urandom % 2));
      else if (r == 7) a = 12'(4 * (NP + ($urandom % (256 - NP))));
      else if (r == 8) a = 12'(4 * (259 + ($urandom % 765)));
      else             a = 12'(4 * ($urandom % NP));
      apb_wr(a, v);
      rd_chk("R3 random readback", 12'(4 * ($urandom % NP)));
      if (n % 60 == 0) begin
        rd_chk("R7 random protect", 12'h400);
        chk_outputs("R3 R4 random outputs");
      end
    end
    chk_outputs("R3 final outputs");
    finish_run();
  end
endmodule